// File: doc/BRIEF.md
# Interleaved I/Q Proportional-Integral Field Controller

This block closes a digital feedback loop on a sampled RF field. The measured field arrives as one stream of signed samples in which in-phase and quadrature components alternate, with a flag that marks each sample as I or Q. A set-point stream carries the wanted vector in the same order, one component per clock. The block forms the error, scales it by a proportional gain, and integrates the scaled error with a second gain. Each component has its own accumulator. The feedback result is then added to a feed-forward drive sample, and the block emits one drive word per clock in the same interleaved order.

Every stage carries one component per clock, so a single lane of arithmetic serves both I and Q. A sample presented before rising edge n leaves the proportional path as a drive word that is visible after edge n+5, which is six register stages including the input stage. The enables for feedback and feed-forward travel with each sample, so switching them takes effect exactly on that sample's output.

Top module: `iq_pi_ctrl`

## Requirements
- R1: The proportional path has a fixed latency of six clock edges. A sample taken at edge n appears on `drive` after edge n+5, and the output for any sample does not depend on samples that arrive later.
- R2: `drive_is_q` equals the `adc_is_q` value of the sample whose result is on `drive` (1 = Q, 0 = I). Any I/Q order is carried through, including irregular ones.
- R3: The error is e = sp − 4·adc, with both values signed and the 17-bit result exact. The proportional term is p = floor(e·kp / 1024) with kp unsigned, so kp = 256 is unity in ADC units. p is clamped to [−8192, 8191].
- R4: The sum of the proportional and integral terms, and the final drive after the feed-forward add, are each clamped to [−8192, 8191] and never wrap.
- R5: I samples update only the I accumulator and Q samples update only the Q accumulator. A Q result never reflects I history, and an I result never reflects Q history.
- R6: For each sample with feedback on, acc[c] ← acc[c] + p·ki, with ki unsigned and c the sample's component. The feedback value is clamp(p + floor(acc[c] / 65536)), and the updated accumulator includes the current sample.
- R7: A sample with `fb_en` low clears both accumulators and contributes zero feedback. Its drive is the feed-forward term alone.
- R8: With `ff_en` high, the sample's `ff_smp` is added to the feedback value. With `ff_en` low, `ff_smp` has no effect on `drive`.
- R9: After reset, `drive` and `drive_is_q` are zero.
- R10: Each accumulator is 41 bits signed and clamps at −2^40 and 2^40−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adc_smp | input | 14 | Measured field component, signed |
| adc_is_q | input | 1 | Component flag for this clock: 1 = Q, 0 = I |
| sp_smp | input | 16 | Set-point component, signed, same order as adc_smp |
| ff_smp | input | 14 | Feed-forward drive component, signed |
| kp | input | 16 | Proportional gain, unsigned, 8 fraction bits relative to ADC units |
| ki | input | 16 | Integral gain per sample, unsigned, 16 fraction bits |
| fb_en | input | 1 | Feedback enable for this sample |
| ff_en | input | 1 | Feed-forward enable for this sample |
| drive | output | 14 | Interleaved drive word, signed |
| drive_is_q | output | 1 | Component flag of the drive word |

## Verification
A single impulse with the integral gain at zero shows where the output moves and shows that no earlier or later sample leaks into it. Alternating and irregular I/Q orders, with a constant error on one component only, show that the accumulators are kept apart and that the flag stays aligned. Mixed-sign errors under several gains separate floor rounding from truncation. Extreme errors and long one-sided integration reach every clamp: proportional, sum, drive and accumulator. Toggling the two enables sample by sample checks the clear of the integrators and the feed-forward pass-through.

// File: rtl/iqpi_pkg.sv
`timescale 1ns/1ps
package iqpi_pkg;
  localparam int SMP_W     = 14;
  localparam int SET_W     = 16;
  localparam int SET_SHIFT = SET_W - SMP_W;
  localparam int SAT_HI    = 2**(SMP_W-1) - 1;
  localparam int SAT_LO    = -(2**(SMP_W-1));

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [SET_W-1:0] set_t;

  typedef struct packed {
    logic q;
    logic fb_on;
    logic ff_on;
    smp_t ff;
  } tag_t;
endpackage

// File: rtl/iqpi_prop.sv
`timescale 1ns/1ps
module iqpi_prop
  import iqpi_pkg::*;
#(
  parameter int GAIN_W  = 16,
  parameter int KP_FRAC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  smp_t              adc_in,
  input  set_t              sp_in,
  input  logic [GAIN_W-1:0] kp,
  input  tag_t              tag_in,
  output smp_t              p_out,
  output tag_t              tag_out
);
  localparam int ERR_W   = SET_W + 1;
  localparam int PRD_W   = ERR_W + GAIN_W + 1;
  localparam int P_SHIFT = KP_FRAC + SET_SHIFT;
  localparam logic signed [PRD_W-1:0] HI_P = PRD_W'(SAT_HI);
  localparam logic signed [PRD_W-1:0] LO_P = PRD_W'(SAT_LO);

  logic signed [ERR_W-1:0] err_r, err_nxt;
  logic signed [PRD_W-1:0] prd_r, prd_nxt, prd_sh;
  smp_t                    p_r, p_nxt;
  tag_t                    t1_r, t2_r, t3_r;

  // stage 1: error against the scaled measurement
  always_comb begin
    err_nxt = ERR_W'(sp_in) - (ERR_W'(adc_in) <<< SET_SHIFT);
  end

  // stage 2: proportional product, gain zero-extended
  always_comb begin
    prd_nxt = $signed(PRD_W'(err_r)) * $signed(PRD_W'({1'b0, kp}));
  end

  // stage 3: scale back and clamp
  always_comb begin
    prd_sh = prd_r >>> P_SHIFT;
    if (prd_sh > HI_P)      p_nxt = smp_t'(SAT_HI);
    else if (prd_sh < LO_P) p_nxt = smp_t'(SAT_LO);
    else                    p_nxt = prd_sh[SMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_r <= '0;
      prd_r <= '0;
      p_r   <= '0;
      t1_r  <= '0;
      t2_r  <= '0;
      t3_r  <= '0;
    end else begin
      err_r <= err_nxt;
      prd_r <= prd_nxt;
      p_r   <= p_nxt;
      t1_r  <= tag_in;
      t2_r  <= t1_r;
      t3_r  <= t2_r;
    end
  end

  assign p_out   = p_r;
  assign tag_out = t3_r;

  // a matched set-point gives a zero proportional term three edges later
  assert_zero_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ERR_W'(sp_in) == (ERR_W'(adc_in) <<< SET_SHIFT)) |=> ##2 (p_r == '0)));
endmodule

// File: rtl/iqpi_integ.sv
`timescale 1ns/1ps
module iqpi_integ
  import iqpi_pkg::*;
#(
  parameter int GAIN_W  = 16,
  parameter int KI_FRAC = 16,
  parameter int ACC_W   = 41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  smp_t              p_in,
  input  tag_t              tag_in,
  input  logic [GAIN_W-1:0] ki,
  output smp_t              fb_out,
  output logic              q_out,
  output logic              ff_on_out,
  output smp_t              ff_out
);
  localparam int IP_W = SMP_W + GAIN_W + 1;
  localparam int SW   = ACC_W + 1;
  localparam logic signed [SW-1:0] ACC_HI = SW'({1'b0, {(ACC_W-1){1'b1}}});
  localparam logic signed [SW-1:0] ACC_LO = ~ACC_HI;
  localparam logic signed [SW-1:0] OUT_HI = SW'(SAT_HI);
  localparam logic signed [SW-1:0] OUT_LO = SW'(SAT_LO);

  logic signed [IP_W-1:0]  ip_r, ip_nxt;
  smp_t                    pd_r;
  tag_t                    t4_r, t5_r;
  logic signed [ACC_W-1:0] acc_i, acc_q, acc_sel, acc_new, itrm;
  logic signed [ACC_W-1:0] acc_i_nxt, acc_q_nxt;
  logic                    acc_i_en, acc_q_en;
  logic signed [SW-1:0]    sum_w, fb_w;
  smp_t                    fb_r, fb_nxt;

  // stage 4: integral product
  always_comb begin
    ip_nxt = $signed(IP_W'(p_in)) * $signed(IP_W'({1'b0, ki}));
  end

  // stage 5: per-component accumulate, clamp, combine with p
  always_comb begin
    acc_sel = t4_r.q ? acc_q : acc_i;
    sum_w   = SW'(acc_sel) + SW'(ip_r);
    if (sum_w > ACC_HI)      acc_new = ACC_HI[ACC_W-1:0];
    else if (sum_w < ACC_LO) acc_new = ACC_LO[ACC_W-1:0];
    else                     acc_new = sum_w[ACC_W-1:0];
    itrm = acc_new >>> KI_FRAC;
    fb_w = SW'(pd_r) + SW'(itrm);

    acc_i_en  = !t4_r.fb_on || !t4_r.q;
    acc_q_en  = !t4_r.fb_on ||  t4_r.q;
    acc_i_nxt = t4_r.fb_on ? acc_new : '0;
    acc_q_nxt = t4_r.fb_on ? acc_new : '0;

    if (!t4_r.fb_on)       fb_nxt = '0;
    else if (fb_w > OUT_HI) fb_nxt = smp_t'(SAT_HI);
    else if (fb_w < OUT_LO) fb_nxt = smp_t'(SAT_LO);
    else                    fb_nxt = fb_w[SMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_r <= '0;
      pd_r <= '0;
      t4_r <= '0;
      t5_r <= '0;
      fb_r <= '0;
    end else begin
      ip_r <= ip_nxt;
      pd_r <= p_in;
      t4_r <= tag_in;
      t5_r <= t4_r;
      fb_r <= fb_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_i <= '0;
    else if (acc_i_en) acc_i <= acc_i_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (acc_q_en) acc_q <= acc_q_nxt;
  end

  assign fb_out    = fb_r;
  assign q_out     = t5_r.q;
  assign ff_on_out = t5_r.ff_on;
  assign ff_out    = t5_r.ff;

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!t4_r.fb_on |=> (acc_i == '0 && acc_q == '0 && fb_r == '0)));
  assert_i_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((t4_r.fb_on && t4_r.q) |=> (acc_i == $past(acc_i))));
  assert_q_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((t4_r.fb_on && !t4_r.q) |=> (acc_q == $past(acc_q))));
endmodule

// File: rtl/iqpi_drive.sv
`timescale 1ns/1ps
module iqpi_drive
  import iqpi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  smp_t fb_in,
  input  logic q_in,
  input  logic ff_on,
  input  smp_t ff_in,
  output smp_t drive_out,
  output logic q_out
);
  localparam int DW = SMP_W + 1;
  localparam logic signed [DW-1:0] HI_D = DW'(SAT_HI);
  localparam logic signed [DW-1:0] LO_D = DW'(SAT_LO);

  logic signed [DW-1:0] dw;
  smp_t                 drv_r, drv_nxt;
  logic                 q_r;

  // stage 6: feed-forward add and clamp
  always_comb begin
    dw = DW'(fb_in) + (ff_on ? DW'(ff_in) : '0);
    if (dw > HI_D)      drv_nxt = smp_t'(SAT_HI);
    else if (dw < LO_D) drv_nxt = smp_t'(SAT_LO);
    else                drv_nxt = dw[SMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_r <= '0;
      q_r   <= 1'b0;
    end else begin
      drv_r <= drv_nxt;
      q_r   <= q_in;
    end
  end

  assign drive_out = drv_r;
  assign q_out     = q_r;

  assert_ff_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ff_on |=> (drv_r == $past(fb_in))));
  assert_ff_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ff_on && fb_in == '0) |=> (drv_r == $past(ff_in))));
endmodule

// File: rtl/iq_pi_ctrl.sv
`timescale 1ns/1ps
module iq_pi_ctrl
  import iqpi_pkg::*;
#(
  parameter int GAIN_W    = 16,
  parameter int KP_FRAC   = 8,
  parameter int KI_FRAC   = 16,
  parameter int PULSE_LEN = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SMP_W-1:0]     adc_smp,
  input  logic                 adc_is_q,
  input  logic [SET_W-1:0]     sp_smp,
  input  logic [SMP_W-1:0]     ff_smp,
  input  logic [GAIN_W-1:0]    kp,
  input  logic [GAIN_W-1:0]    ki,
  input  logic                 fb_en,
  input  logic                 ff_en,
  output logic [SMP_W-1:0]     drive,
  output logic                 drive_is_q
);
  localparam int ACC_W = SMP_W + GAIN_W + 1 + $clog2(PULSE_LEN);

  logic [1:0] rst_sync;
  logic       rst_sn;
  tag_t       tag_in, tag_p;
  smp_t       p_val, fb_val, ff5, drv;
  logic       q5, ffon5, q6;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  always_comb begin
    tag_in.q     = adc_is_q;
    tag_in.fb_on = fb_en;
    tag_in.ff_on = ff_en;
    tag_in.ff    = smp_t'(ff_smp);
  end

  iqpi_prop #(.GAIN_W(GAIN_W), .KP_FRAC(KP_FRAC)) u_prop (
    .clk(clk), .rst_n(rst_sn),
    .adc_in(smp_t'(adc_smp)), .sp_in(set_t'(sp_smp)), .kp(kp),
    .tag_in(tag_in), .p_out(p_val), .tag_out(tag_p)
  );

  iqpi_integ #(.GAIN_W(GAIN_W), .KI_FRAC(KI_FRAC), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_sn),
    .p_in(p_val), .tag_in(tag_p), .ki(ki),
    .fb_out(fb_val), .q_out(q5), .ff_on_out(ffon5), .ff_out(ff5)
  );

  iqpi_drive u_drive (
    .clk(clk), .rst_n(rst_sn),
    .fb_in(fb_val), .q_in(q5), .ff_on(ffon5), .ff_in(ff5),
    .drive_out(drv), .q_out(q6)
  );

  assign drive      = drv;
  assign drive_is_q = q6;

  assert_flag_follow_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (1'b1 |=> (drive_is_q == $past(q5))));
endmodule

// File: tb/test_iq_pi_ctrl.sv
`timescale 1ns/1ps
module test_iq_pi_ctrl;
  localparam int  MAX_CYC = 150000;
  localparam longint A_HI = (64'sd1 <<< 40) - 1;
  localparam longint A_LO = -(64'sd1 <<< 40);

  logic        clk;
  logic        rst_n;
  logic [13:0] adc_smp;
  logic        adc_is_q;
  logic [15:0] sp_smp;
  logic [13:0] ff_smp;
  logic [15:0] kp, ki;
  logic        fb_en, ff_en;
  logic [13:0] drive;
  logic        drive_is_q;

  int n_chk, n_fail, slot;
  string cur_req;
  int    pd[6];
  bit    pq[6];
  bit    pv[6];
  string ptag[6];
  longint acc_m[2];

  iq_pi_ctrl i_iq_pi_ctrl (
    .clk(clk), .rst_n(rst_n), .adc_smp(adc_smp), .adc_is_q(adc_is_q),
    .sp_smp(sp_smp), .ff_smp(ff_smp), .kp(kp), .ki(ki),
    .fb_en(fb_en), .ff_en(ff_en), .drive(drive), .drive_is_q(drive_is_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint clamp(input longint v, input longint lo, input longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  task automatic check_out(input int exp_d, input bit exp_q, input string tag);
    n_chk++;
    if (int'($signed(drive)) != exp_d || drive_is_q != exp_q) begin
      n_fail++;
      $display("FAIL %s: drive=%0d q=%0d expected drive=%0d q=%0d",
               tag, $signed(drive), drive_is_q, exp_d, exp_q);
    end
  endtask

  // one sample per call; checks the result of the sample six calls back
  task automatic step(input int adc, input int sp, input int ff,
                      input bit q, input bit fb, input bit ffe);
    longint e, p, a, fbv;
    @(negedge clk);
    if (pv[slot]) check_out(pd[slot], pq[slot], ptag[slot]);
    adc_smp  = adc[13:0];
    sp_smp   = sp[15:0];
    ff_smp   = ff[13:0];
    adc_is_q = q;
    fb_en    = fb;
    ff_en    = ffe;
    if (fb) begin
      e   = longint'(sp) - 4 * longint'(adc);
      p   = clamp((e * longint'(kp)) >>> 10, -8192, 8191);
      a   = clamp(acc_m[q] + p * longint'(ki), A_LO, A_HI);
      acc_m[q] = a;
      fbv = clamp(p + (a >>> 16), -8192, 8191);
    end else begin
      acc_m[0] = 0;
      acc_m[1] = 0;
      fbv = 0;
    end
    pd[slot]   = int'(clamp(fbv + (ffe ? longint'(ff) : 0), -8192, 8191));
    pq[slot]   = q;
    pv[slot]   = 1'b1;
    ptag[slot] = cur_req;
    slot = (slot + 1) % 6;
  endtask

  task automatic flush;
    for (int k = 0; k < 6; k++) step(0, 0, 0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    cur_req = "R9";
    @(negedge clk);
    check_out(0, 1'b0, "R9 reset drive");
  endtask

  task automatic t_latency;
    cur_req = "R1";
    kp = 16'd256; ki = 16'd0;
    for (int k = 0; k < 4; k++) step(0, 0, 0, k[0], 1'b1, 1'b0);
    step(0, 4000, 0, 1'b0, 1'b1, 1'b0);   // impulse: 1000 out after edge n+5
    for (int k = 0; k < 8; k++) step(0, 0, 0, ~k[0], 1'b1, 1'b0);
    flush();
  endtask

  task automatic t_interleave;
    cur_req = "R2";
    kp = 16'd256; ki = 16'd1000;
    for (int k = 0; k < 24; k++)
      step(k * 3 - 30, 200 - k * 17, 0, (k % 3) == 2, 1'b1, 1'b0);
    for (int k = 0; k < 10; k++) step(5, 100, 0, 1'b1, 1'b1, 1'b0);
    flush();
  endtask

  task automatic t_prop;
    cur_req = "R3";
    ki = 16'd0;
    kp = 16'd256;
    step(100, 1000, 0, 1'b0, 1'b1, 1'b0);
    step(-50, -3, 0, 1'b1, 1'b1, 1'b0);
    step(7, 1, 0, 1'b0, 1'b1, 1'b0);
    flush();
    kp = 16'd300;
    step(-1000, 5000, 0, 1'b0, 1'b1, 1'b0);
    step(333, -777, 0, 1'b1, 1'b1, 1'b0);
    flush();
    kp = 16'd77;
    step(2, 13, 0, 1'b0, 1'b1, 1'b0);
    step(-3, -1, 0, 1'b1, 1'b1, 1'b0);
    flush();
  endtask

  task automatic t_sat;
    cur_req = "R4";
    ki = 16'd0;
    kp = 16'd65535;
    step(-8192, 32767, 0, 1'b0, 1'b1, 1'b0);
    step(8191, -32768, 0, 1'b1, 1'b1, 1'b0);
    flush();
    kp = 16'd256;
    step(0, 32000, 8000, 1'b0, 1'b1, 1'b1);
    step(0, -32000, -8000, 1'b1, 1'b1, 1'b1);
    step(0, 400, 8191, 1'b0, 1'b1, 1'b1);
    flush();
  endtask

  task automatic t_separate;
    cur_req = "R5";
    kp = 16'd256; ki = 16'd4096;
    for (int k = 0; k < 40; k++) begin
      step(0, 400, 0, 1'b0, 1'b1, 1'b0);
      step(0, 0, 0, 1'b1, 1'b1, 1'b0);
    end
    for (int k = 0; k < 20; k++) begin
      step(0, 0, 0, 1'b0, 1'b1, 1'b0);
      step(10, 0, 0, 1'b1, 1'b1, 1'b0);
    end
    flush();
  endtask

  task automatic t_integ;
    cur_req = "R6";
    kp = 16'd128; ki = 16'd20000;
    for (int k = 0; k < 60; k++)
      step((k * 37) % 200 - 100, (k * 53) % 900 - 450, 0, k[0], 1'b1, 1'b0);
    flush();
  endtask

  task automatic t_fb_off;
    cur_req = "R7";
    kp = 16'd256; ki = 16'd30000;
    for (int k = 0; k < 20; k++) step(0, 800, 0, k[0], 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) step(0, 800, 100 + k, k[0], 1'b0, 1'b1);
    for (int k = 0; k < 10; k++) step(0, 800, 0, k[0], 1'b1, 1'b0);
    flush();
  endtask

  task automatic t_ff;
    cur_req = "R8";
    kp = 16'd256; ki = 16'd0;
    step(0, 0, 1234, 1'b0, 1'b0, 1'b1);
    step(0, 0, -555, 1'b1, 1'b0, 1'b1);
    step(0, 0, 4321, 1'b0, 1'b0, 1'b0);
    step(0, 2000, -2000, 1'b1, 1'b1, 1'b0);
    step(0, 2000, -300, 1'b0, 1'b1, 1'b1);
    flush();
  endtask

  task automatic t_acc_clamp;
    cur_req = "R10";
    kp = 16'd256; ki = 16'd65535;
    for (int k = 0; k < 2100; k++) begin
      step(0, 32767, 0, 1'b0, 1'b1, 1'b0);
      step(0, 32767, 0, 1'b1, 1'b1, 1'b0);
    end
    for (int k = 0; k < 40; k++) begin
      step(0, -32768, 0, 1'b0, 1'b1, 1'b0);
      step(0, -32768, 0, 1'b1, 1'b1, 1'b0);
    end
    flush();
  endtask

  initial begin
    #(20.0 * MAX_CYC);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected finish");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; slot = 0;
    acc_m[0] = 0; acc_m[1] = 0;
    for (int k = 0; k < 6; k++) pv[k] = 1'b0;
    cur_req = "R9";
    rst_n = 1'b0;
    adc_smp = '0; sp_smp = '0; ff_smp = '0; adc_is_q = 1'b0;
    kp = '0; ki = '0; fb_en = 1'b0; ff_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latency();
    t_interleave();
    t_prop();
    t_sat();
    t_separate();
    t_integ();
    t_fb_off();
    t_ff();
    t_acc_clamp();
    summary();
    $finish;
  end
endmodule